// File: doc/BRIEF.md
# Victim Line Buffer

This block sits on the miss path between a primary cache and the next memory level. It keeps a handful of lines that the primary cache has just thrown out, because a line evicted by a conflict is often wanted again soon. Every slot may hold any line, so a lookup compares the requested line address against all held tags at once. Lines enter only through the evict port. A memory fill never places a line here.

When the primary cache misses, it presents the line address on the lookup port. On a hit, the line and its dirty flag come back to the primary cache one cycle later and the slot is freed. If the primary cache is evicting a line in the same cycle, that line takes the freed slot, so the two lines trade places in one step. On a miss, a forward-to-memory flag is raised combinationally in the lookup cycle. An evicted line that arrives when every slot is full displaces the least recently filled slot. The displaced line goes out on the write-back port if it is dirty and is dropped if it is clean. The environment keeps the contents exclusive: a line that is held here is never evicted into the buffer again until a hit has returned it.

Top module: `vcache_top`

## Requirements
- R1: After reset every slot is empty, `rt_valid`, `wb_valid` and `mem_fwd` are 0, and any lookup misses.
- R2: An eviction (`ev_req`=1) without a lookup stores the line, and a later lookup of its tag hits.
- R3: A lookup that hits keeps `mem_fwd` at 0 and drives `rt_valid`=1 in the following cycle, with `rt_data` and `rt_dirty` equal to the stored line's data and dirty flag.
- R4: A lookup that misses drives `mem_fwd`=1 in the same cycle, and `rt_valid` is 0 in the following cycle.
- R5: A hit with a simultaneous eviction removes the hit line and stores the evicted line in its place. No write-back results and occupancy is unchanged. A second lookup of the old tag misses and a lookup of the new tag hits.
- R6: A hit without an eviction empties the hit slot, so a repeated lookup of the same tag misses.
- R7: While a free slot exists, an eviction fills it and produces no write-back.
- R8: When all slots are full, an eviction replaces the line whose last fill is oldest. A fill by a plain eviction and a fill by a swap both count as the newest.
- R9: A displaced dirty line appears one cycle after the eviction with `wb_valid`=1 and its `wb_tag` and `wb_data`. A displaced clean line leaves `wb_valid` at 0.
- R10: A missing lookup combined with an eviction raises `mem_fwd` and still stores the evicted line, displacing a slot under R8 and R9 if the buffer is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request from the primary cache |
| lk_tag | input | TAG_W | Line address to look up |
| ev_req | input | 1 | Line evicted by the primary cache |
| ev_tag | input | TAG_W | Line address of the evicted line |
| ev_dirty | input | 1 | Evicted line is modified |
| ev_data | input | LINE_W | Evicted line contents |
| rt_valid | output | 1 | Returned line valid (cycle after a hit) |
| rt_data | output | LINE_W | Returned line contents |
| rt_dirty | output | 1 | Returned line is modified |
| mem_fwd | output | 1 | Lookup missed; forward request to memory |
| wb_valid | output | 1 | Dirty displaced line to write back |
| wb_tag | output | TAG_W | Line address of the write-back |
| wb_data | output | LINE_W | Contents of the write-back |

## Verification
The assertions check several properties on every cycle. The ages of the occupied slots always form a compact set with no gaps. A swap leaves the occupancy unchanged. A return is only ever preceded by a hitting lookup, and a miss is never followed by a return. A write-back only ever follows an eviction that did not swap. Other behaviour can only be shown by the bench scenarios, which track line contents in a reference model: that returned data matches what was stored, that replacement picks the line whose fill is oldest, that clean displaced lines vanish, and that freed slots are really empty.

// File: rtl/vc_pkg.sv
package vc_pkg;

  typedef enum logic [1:0] {
    VC_IDLE   = 2'd0,
    VC_INSERT = 2'd1,
    VC_SWAP   = 2'd2,
    VC_DROP   = 2'd3
  } vc_op_e;

  // New age of an untouched occupied slot, given the old age of the touched slot.
  // Fill: younger slots age by one. Drop: older slots close the gap.
  function automatic int unsigned vc_age_step(int unsigned age, int unsigned ref_age, vc_op_e op);
    if (op == VC_IDLE) return age;
    if (op == VC_DROP) return (age > ref_age) ? age - 1 : age;
    return (age < ref_age) ? age + 1 : age;
  endfunction

endpackage

// File: rtl/vc_match.sv
module vc_match #(
  parameter  int ENTRIES = 4,
  parameter  int TAG_W   = 20,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic [TAG_W-1:0]   probe,
  input  logic [TAG_W-1:0]   tags [ENTRIES],
  input  logic [ENTRIES-1:0] valid,
  output logic [ENTRIES-1:0] hit_vec,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = valid[g] && (tags[g] == probe);
  end

  assign any = |hit_vec;

  always_comb begin
    idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hit_vec[i]) idx = IDX_W'(i);
  end

endmodule

// File: rtl/vc_age.sv
module vc_age
  import vc_pkg::*;
#(
  parameter  int ENTRIES = 4,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int AGE_W   = IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  vc_op_e             op,
  input  logic [IDX_W-1:0]   slot,
  input  logic [ENTRIES-1:0] valid,
  output logic [IDX_W-1:0]   victim
);

  logic [AGE_W-1:0]   age_q [ENTRIES];
  int unsigned        occ;
  int unsigned        ref_age;
  logic [ENTRIES-1:0] ages_seen;
  logic [ENTRIES-1:0] ages_low;

  always_comb begin
    occ     = $countones(valid);
    ref_age = valid[slot] ? int'(age_q[slot]) : occ;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) age_q[i] <= '0;
    end else if (op != VC_IDLE) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IDX_W'(i) == slot)
          age_q[i] <= '0;
        else if (valid[i])
          age_q[i] <= AGE_W'(vc_age_step(int'(age_q[i]), ref_age, op));
      end
    end
  end

  always_comb begin
    victim = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (valid[i] && age_q[i] == AGE_W'(ENTRIES - 1)) victim = IDX_W'(i);
  end

  // Ages of the occupied slots are exactly 0 .. occ-1.
  always_comb begin
    ages_seen = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (valid[i]) ages_seen[age_q[i]] = 1'b1;
    ages_low = ENTRIES'((64'd1 << occ) - 64'd1);
  end

  p_ages_compact_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ages_seen == ages_low);

endmodule

// File: rtl/vc_store.sv
module vc_store
  import vc_pkg::*;
#(
  parameter  int ENTRIES = 4,
  parameter  int TAG_W   = 20,
  parameter  int LINE_W  = 32,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  vc_op_e             op,
  input  logic [IDX_W-1:0]   slot,
  input  logic [TAG_W-1:0]   w_tag,
  input  logic [LINE_W-1:0]  w_data,
  input  logic               w_dirty,
  output logic [TAG_W-1:0]   tags  [ENTRIES],
  output logic [LINE_W-1:0]  lines [ENTRIES],
  output logic [ENTRIES-1:0] dirty,
  output logic [ENTRIES-1:0] valid
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= '0;
      dirty <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tags[i]  <= '0;
        lines[i] <= '0;
      end
    end else begin
      unique case (op)
        VC_INSERT, VC_SWAP: begin
          valid[slot] <= 1'b1;
          dirty[slot] <= w_dirty;
          tags[slot]  <= w_tag;
          lines[slot] <= w_data;
        end
        VC_DROP: begin
          valid[slot] <= 1'b0;
          dirty[slot] <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  p_swap_occupancy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op == VC_SWAP |=> $countones(valid) == $past($countones(valid)));

  p_drop_frees_r6: assert property (@(posedge clk) disable iff (!rst_n)
    op == VC_DROP |=> $countones(valid) + 1 == $past($countones(valid)));

endmodule

// File: rtl/vcache_top.sv
module vcache_top
  import vc_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int TAG_W   = 20,
  parameter int LINE_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_req,
  input  logic [TAG_W-1:0]  lk_tag,
  input  logic              ev_req,
  input  logic [TAG_W-1:0]  ev_tag,
  input  logic              ev_dirty,
  input  logic [LINE_W-1:0] ev_data,
  output logic              rt_valid,
  output logic [LINE_W-1:0] rt_data,
  output logic              rt_dirty,
  output logic              mem_fwd,
  output logic              wb_valid,
  output logic [TAG_W-1:0]  wb_tag,
  output logic [LINE_W-1:0] wb_data
);

  localparam int IDX_W = $clog2(ENTRIES);

  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [LINE_W-1:0]  line_q [ENTRIES];
  logic [ENTRIES-1:0] dirty_q;
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] hit_vec;
  logic               match_any;
  logic [IDX_W-1:0]   hit_idx;
  logic [IDX_W-1:0]   victim_idx;
  logic [IDX_W-1:0]   free_idx;
  logic               free_any;
  logic               lk_hit;
  logic               displace;
  vc_op_e             op;
  logic [IDX_W-1:0]   slot;

  vc_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_match (
    .probe(lk_tag), .tags(tag_q), .valid(valid_q),
    .hit_vec(hit_vec), .any(match_any), .idx(hit_idx)
  );

  vc_age #(.ENTRIES(ENTRIES)) u_age (
    .clk(clk), .rst_n(rst_n), .op(op), .slot(slot),
    .valid(valid_q), .victim(victim_idx)
  );

  vc_store #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .op(op), .slot(slot),
    .w_tag(ev_tag), .w_data(ev_data), .w_dirty(ev_dirty),
    .tags(tag_q), .lines(line_q), .dirty(dirty_q), .valid(valid_q)
  );

  // Lowest-numbered empty slot.
  always_comb begin
    free_idx = '0;
    free_any = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!valid_q[i]) begin
        free_idx = IDX_W'(i);
        free_any = 1'b1;
      end
  end

  assign lk_hit  = lk_req && match_any;
  assign mem_fwd = lk_req && !match_any;

  always_comb begin
    op   = VC_IDLE;
    slot = '0;
    if (lk_hit) begin
      op   = ev_req ? VC_SWAP : VC_DROP;
      slot = hit_idx;
    end else if (ev_req) begin
      op   = VC_INSERT;
      slot = free_any ? free_idx : victim_idx;
    end
  end

  assign displace = (op == VC_INSERT) && !free_any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rt_valid <= 1'b0;
      rt_data  <= '0;
      rt_dirty <= 1'b0;
      wb_valid <= 1'b0;
      wb_tag   <= '0;
      wb_data  <= '0;
    end else begin
      rt_valid <= lk_hit;
      if (lk_hit) begin
        rt_data  <= line_q[hit_idx];
        rt_dirty <= dirty_q[hit_idx];
      end
      wb_valid <= displace && dirty_q[victim_idx];
      if (displace) begin
        wb_tag  <= tag_q[victim_idx];
        wb_data <= line_q[victim_idx];
      end
    end
  end

  p_miss_no_return_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_fwd |=> !rt_valid);

  p_return_after_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rt_valid |-> $past(lk_req) && !$past(mem_fwd));

  p_wb_after_insert_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $past(ev_req) && $past(!lk_req || mem_fwd));

endmodule

// File: tb/test_vcache_top.sv
module test_vcache_top;

  localparam int ENTRIES = 4;
  localparam int TAG_W   = 20;
  localparam int LINE_W  = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              lk_req = 1'b0;
  logic [TAG_W-1:0]  lk_tag = '0;
  logic              ev_req = 1'b0;
  logic [TAG_W-1:0]  ev_tag = '0;
  logic              ev_dirty = 1'b0;
  logic [LINE_W-1:0] ev_data = '0;
  logic              rt_valid, rt_dirty, mem_fwd, wb_valid;
  logic [LINE_W-1:0] rt_data, wb_data;
  logic [TAG_W-1:0]  wb_tag;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // Reference model: lines ordered oldest fill first.
  logic [TAG_W-1:0]  m_tag   [ENTRIES];
  logic [LINE_W-1:0] m_data  [ENTRIES];
  logic              m_dirty [ENTRIES];
  int                m_n = 0;
  logic [TAG_W-1:0]  fresh = 20'h01000;

  always #5 clk = ~clk;

  vcache_top #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .LINE_W(LINE_W)) i_vcache_top (
    .clk(clk), .rst_n(rst_n),
    .lk_req(lk_req), .lk_tag(lk_tag),
    .ev_req(ev_req), .ev_tag(ev_tag), .ev_dirty(ev_dirty), .ev_data(ev_data),
    .rt_valid(rt_valid), .rt_data(rt_data), .rt_dirty(rt_dirty),
    .mem_fwd(mem_fwd),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data)
  );

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int m_find(logic [TAG_W-1:0] t);
    for (int i = 0; i < m_n; i++) if (m_tag[i] == t) return i;
    return -1;
  endfunction

  function automatic void m_remove(int k);
    for (int i = k; i < m_n - 1; i++) begin
      m_tag[i]   = m_tag[i+1];
      m_data[i]  = m_data[i+1];
      m_dirty[i] = m_dirty[i+1];
    end
    m_n--;
  endfunction

  function automatic void m_append(logic [TAG_W-1:0] t, logic [LINE_W-1:0] d, logic dy);
    m_tag[m_n]   = t;
    m_data[m_n]  = d;
    m_dirty[m_n] = dy;
    m_n++;
  endfunction

  function automatic logic [TAG_W-1:0] next_tag();
    fresh = fresh + 1'b1;
    return fresh;
  endfunction

  // Called at a falling edge; returns at the next falling edge.
  task automatic op(input logic lk, input logic [TAG_W-1:0] lt,
                    input logic ev, input logic [TAG_W-1:0] et,
                    input logic ed, input logic [LINE_W-1:0] edat, input string req);
    int               k;
    logic             x_fwd, x_rt, x_rdirty, x_wb;
    logic [LINE_W-1:0] x_rdata, x_wdata;
    logic [TAG_W-1:0] x_wtag;
    lk_req = lk; lk_tag = lt; ev_req = ev; ev_tag = et; ev_dirty = ed; ev_data = edat;
    k        = lk ? m_find(lt) : -1;
    x_fwd    = lk && (k < 0);
    x_rt     = (k >= 0);
    x_rdata  = '0; x_rdirty = 1'b0;
    x_wb     = 1'b0; x_wtag = '0; x_wdata = '0;
    if (x_rt) begin
      x_rdata = m_data[k]; x_rdirty = m_dirty[k];
      m_remove(k);
    end else if (ev && m_n == ENTRIES) begin
      x_wb = m_dirty[0]; x_wtag = m_tag[0]; x_wdata = m_data[0];
      m_remove(0);
    end
    if (ev) m_append(et, edat, ed);
    #1;
    check(req, x_fwd ? "mem_fwd on miss (R4)" : "mem_fwd quiet (R3)", 64'(mem_fwd), 64'(x_fwd));
    @(posedge clk);
    #1;
    lk_req = 1'b0; ev_req = 1'b0;
    @(negedge clk);
    check(req, "rt_valid (R3/R4)", 64'(rt_valid), 64'(x_rt));
    if (x_rt) begin
      check(req, "rt_data (R3)", 64'(rt_data), 64'(x_rdata));
      check(req, "rt_dirty (R3)", 64'(rt_dirty), 64'(x_rdirty));
    end
    check(req, "wb_valid (R9)", 64'(wb_valid), 64'(x_wb));
    if (x_wb) begin
      check(req, "wb_tag (R9)", 64'(wb_tag), 64'(x_wtag));
      check(req, "wb_data (R9)", 64'(wb_data), 64'(x_wdata));
    end
  endtask

  task automatic look(input logic [TAG_W-1:0] t, input string req);
    op(1'b1, t, 1'b0, '0, 1'b0, '0, req);
  endtask

  task automatic evict(input logic [TAG_W-1:0] t, input logic dy, input logic [LINE_W-1:0] d,
                       input string req);
    op(1'b0, '0, 1'b1, t, dy, d, req);
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    if (!done) $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [TAG_W-1:0] t;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: empty after reset
    check("R1", "rt_valid after reset", 64'(rt_valid), 64'd0);
    check("R1", "wb_valid after reset", 64'(wb_valid), 64'd0);
    check("R1", "mem_fwd after reset", 64'(mem_fwd), 64'd0);
    look(20'h00011, "R1");

    // R2, R3, R6: insert, hit, slot freed
    evict(20'h00021, 1'b1, 32'hAAAA_0001, "R2");
    look(20'h00021, "R2");
    look(20'h00021, "R6");

    // R7: fill all slots, no write-back
    evict(20'h00031, 1'b1, 32'hB000_0001, "R7");
    evict(20'h00032, 1'b0, 32'hB000_0002, "R7");
    evict(20'h00033, 1'b1, 32'hB000_0003, "R7");
    evict(20'h00034, 1'b0, 32'hB000_0004, "R7");

    // R8/R9: oldest dirty line written back, then oldest clean line dropped
    evict(20'h00035, 1'b0, 32'hB000_0005, "R8");
    evict(20'h00036, 1'b1, 32'hB000_0006, "R9");

    // R5: swap with 0x33, then old tag misses and new one hits
    op(1'b1, 20'h00033, 1'b1, 20'h00041, 1'b1, 32'hC000_0041, "R5");
    look(20'h00033, "R5");
    look(20'h00041, "R5");

    // R10: miss with eviction into a partly filled then full buffer
    op(1'b1, 20'h00077, 1'b1, 20'h00042, 1'b0, 32'hC000_0042, "R10");
    op(1'b1, 20'h00078, 1'b1, 20'h00043, 1'b1, 32'hC000_0043, "R10");
    look(20'h00042, "R10");

    // R8: swap fill counts as newest
    op(1'b1, 20'h00043, 1'b1, 20'h00044, 1'b0, 32'hC000_0044, "R8");
    evict(20'h00045, 1'b1, 32'hC000_0045, "R8");
    evict(20'h00046, 1'b1, 32'hC000_0046, "R8");

    // Random traffic
    for (int n = 0; n < 400; n++) begin
      logic do_lk, do_ev;
      do_lk = ($urandom % 2) == 0;
      do_ev = ($urandom % 2) == 0;
      if (do_lk && m_n > 0 && ($urandom % 10) < 6) t = m_tag[$urandom % m_n];
      else t = next_tag();
      op(do_lk, t, do_ev, next_tag(), 1'($urandom), $urandom, "R3/R4/R8/R9 random");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule